// File: doc/BRIEF.md
# Programmable-Cell Infrared Bit Recovery

This block turns a clean, already demodulated infrared receive level into a bit stream that a UART receiver can sample. It is built for a remote-control style link where the cell time is set by a 12-bit programmed value. One cell lasts `cell_len + 1` ticks of the clock enable `tick`. Every level change on the input is a cell boundary and restarts the internal cell timer. While the input stays constant, the block samples it again at the middle of every further cell. The recovered level is driven on `bit_out`. It changes only at those mid-cell sampling points, so each recovered bit is held for a whole cell. This gives a host UART running at least 20 % faster than the cell rate a stable value to sample.

The input goes through a short synchroniser before edge detection, and all state advances only on ticks. Pulses too short to reach a mid-cell sampling point are dropped from the output and reported on `frame_err`. When the block is disabled or has just left reset, `bit_out` rests at the idle-high UART line level. The output is a plain line level with no handshake: the UART samples it at its own rate and cannot push back.

Top module: `irx_bit_decoder`

## Requirements
- R1: After reset, `bit_out` is 1 and `frame_err` is 0.
- R2: One tick after `enable` is seen low, `bit_out` is 1 and `frame_err` is 0, whatever the input does.
- R3: A cell lasts `cell_len + 1` ticks. The tick at which a synchronised edge is seen counts as phase 0, and the mid-cell sample is taken at phase `floor(cell_len/2)`.
- R4: With two synchroniser stages and `tick` held high, a level first applied before rising clock edge k appears on `bit_out` just after edge k+2+floor(cell_len/2). This holds when the level lasts longer than floor(cell_len/2) ticks.
- R5: While the input holds one level, it is sampled once per cell at every later mid-cell point, and `bit_out` holds that level for the whole run.
- R6: Each input edge restarts the cell timer, including edges that fall inside a cell. Runs whose length is not a whole number of cells are recovered with the timing of R4.
- R7: A level lasting at most floor(cell_len/2) ticks never reaches `bit_out`. The edge that ends it makes `frame_err` 1 for one tick, just after edge k+2, where k is the first rising edge that sees the closing level. Runs longer than that never raise `frame_err`.
- R8: While `tick` is 0, neither output and no internal state changes. An input change made during such a pause is handled as if it had been applied at the tick that resumes.
- R9: `cell_len` = 0 is legal and recovers one bit per tick, delayed by two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable that defines the timing unit |
| enable | input | 1 | Block enable; low forces the idle state |
| cell_len | input | 12 | Cell time minus one, in ticks |
| rx_level | input | 1 | Demodulated receive level (asynchronous) |
| bit_out | output | 1 | Recovered level toward the UART receive line |
| frame_err | output | 1 | One-tick flag for a dropped short pulse |

## Verification
With `tick` held high, a new input level is due on `bit_out` 2 + floor(cell_len/2) rising edges after the first edge that sees it. Each further sample of a constant run follows one cell later. The short-pulse flag is due two edges after the closing level is first seen, and forced idle is due one edge after `enable` falls. The bench applies every input change just after a falling edge and samples outputs on later falling edges. It counts falling edges from the start of each run to reach exactly the cycle where a result has settled, and it also checks the cycle just before a due result so that an early change is caught.

// File: rtl/irx_pkg.sv
package irx_pkg;
  localparam int unsigned CELL_W = 12;

  // Synchronised receive level plus a one-tick edge marker.
  typedef struct packed {
    logic level;
    logic edge_seen;
  } rx_evt_t;
endpackage

// File: rtl/irx_sync.sv
module irx_sync #(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             din,
  output irx_pkg::rx_evt_t evt
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev_lvl;

  // Resets to the idle line level so leaving reset makes no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain    <= '1;
      prev_lvl <= 1'b1;
    end else if (tick) begin
      for (int i = STAGES - 1; i > 0; i--) chain[i] <= chain[i-1];
      chain[0] <= din;
      prev_lvl <= chain[LAST];
    end
  end

  assign evt.level     = chain[LAST];
  assign evt.edge_seen = chain[LAST] ^ prev_lvl;
endmodule

// File: rtl/irx_cell_timer.sv
module irx_cell_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] cell_len,
  output logic         centre
);
  logic [W-1:0] cnt;
  logic [W-1:0] phase;
  logic [W-1:0] mid;

  // The edge tick itself is phase 0 of the new cell.
  assign phase  = restart ? '0 : cnt;
  assign mid    = cell_len >> 1;
  assign centre = tick & en & (phase == mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      if (!en)                   cnt <= '0;
      else if (phase >= cell_len) cnt <= '0;
      else                       cnt <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/irx_hold.sv
module irx_hold (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             centre,
  input  irx_pkg::rx_evt_t evt,
  output logic             bit_out,
  output logic             frame_err
);
  // Set by an edge whose cell has not yet reached its mid-cell sample.
  logic unsampled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out   <= 1'b1;
      frame_err <= 1'b0;
      unsampled <= 1'b0;
    end else if (tick) begin
      if (!en) begin
        bit_out   <= 1'b1;
        frame_err <= 1'b0;
        unsampled <= 1'b0;
      end else begin
        frame_err <= evt.edge_seen & unsampled;
        if (centre) begin
          bit_out   <= evt.level;
          unsampled <= 1'b0;
        end else if (evt.edge_seen) begin
          unsampled <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irx_bit_decoder.sv
module irx_bit_decoder #(
  parameter int CELL_W      = irx_pkg::CELL_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic [CELL_W-1:0] cell_len,
  input  logic              rx_level,
  output logic              bit_out,
  output logic              frame_err
);
  irx_pkg::rx_evt_t evt;
  logic             centre;

  irx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .din   (rx_level),
    .evt   (evt)
  );

  irx_cell_timer #(.W(CELL_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (enable),
    .restart  (evt.edge_seen),
    .cell_len (cell_len),
    .centre   (centre)
  );

  irx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .en        (enable),
    .centre    (centre),
    .evt       (evt),
    .bit_out   (bit_out),
    .frame_err (frame_err)
  );
endmodule

// File: rtl/irx_bit_decoder_chk.sv
module irx_bit_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic enable,
  input logic bit_out,
  input logic frame_err
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bit_out && !frame_err));

  // R2
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !enable) |=> (bit_out && !frame_err));

  // R8
  tick_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(bit_out) && $stable(frame_err)));

  // R7
  err_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(enable) && $past(tick)));

  // R5
  out_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_out) |-> $past(tick));
endmodule

bind irx_bit_decoder irx_bit_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .enable    (enable),
  .bit_out   (bit_out),
  .frame_err (frame_err)
);

// File: tb/tb_irx_bit_decoder.sv
module tb_irx_bit_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int NR = 6;
  // Cell length register per vector, and the run lengths in ticks.
  // Runs alternate levels, starting low.
  localparam int VEC_LEN [NV] = '{0, 3, 7, 10, 2};
  localparam int VEC_RUN [NV][NR] = '{
    '{1, 1, 2, 1, 3, 1},
    '{4, 4, 8, 4, 12, 4},
    '{8, 20, 8, 5, 16, 8},
    '{11, 33, 6, 11, 7, 22},
    '{3, 2, 9, 3, 3, 6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        enable = 1'b0;
  logic [11:0] cell_len = '0;
  logic        rx_level = 1'b1;
  logic        bit_out;
  logic        frame_err;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  bit  seen_err = 1'b0;
  bit  seen_low = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irx_bit_decoder dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .enable    (enable),
    .cell_len  (cell_len),
    .rx_level  (rx_level),
    .bit_out   (bit_out),
    .frame_err (frame_err)
  );

  always @(negedge clk) begin
    if (frame_err) seen_err = 1'b1;
    if (!bit_out)  seen_low = 1'b1;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vector(input int v);
    int p;
    int c;
    p = VEC_LEN[v];
    c = p / 2;
    cell_len = 12'(p);
    @(negedge clk);
    enable   = 1'b1;
    seen_err = 1'b0;
    fork
      begin
        for (int j = 0; j < NR; j++) begin
          rx_level = (j % 2 == 0) ? 1'b0 : 1'b1;
          repeat (VEC_RUN[v][j]) @(negedge clk);
        end
      end
      begin
        int pos = 0;
        int start = 0;
        for (int j = 0; j < NR; j++) begin
          for (int off = c; off < VEC_RUN[v][j]; off += p + 1) begin
            int target = start + 3 + off;
            repeat (target - pos) @(negedge clk);
            pos = target;
            check("R3 R4 R5 R6 R9 mid-cell level", bit_out,
                  (j % 2 == 0) ? 1'b0 : 1'b1);
          end
          start += VEC_RUN[v][j];
        end
      end
    join
    check("R7 no flag on clean runs", seen_err, 1'b0);
    @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 bit_out in reset", bit_out, 1'b1);
    check("R1 frame_err in reset", frame_err, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 bit_out after reset", bit_out, 1'b1);

    for (int v = 0; v < NV; v++) run_vector(v);

    // R8: tick low freezes, then R4 latency from the resuming tick
    cell_len = 12'd3;
    enable   = 1'b1;
    rx_level = 1'b1;
    repeat (12) @(negedge clk);
    tick     = 1'b0;
    rx_level = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 bit_out frozen", bit_out, 1'b1);
    check("R8 frame_err frozen", frame_err, 1'b0);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 not before due edge", bit_out, 1'b1);
    @(negedge clk);
    check("R4 due after k+2+mid", bit_out, 1'b0);

    // R2: disable forces idle on the next tick
    repeat (6) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 idle when disabled", bit_out, 1'b1);
    check("R2 no flag when disabled", frame_err, 1'b0);

    // R7: runt of exactly mid ticks (cell_len 9, mid 4) is dropped
    cell_len = 12'd9;
    rx_level = 1'b1;
    enable   = 1'b1;
    repeat (30) @(negedge clk);
    seen_low = 1'b0;
    rx_level = 1'b0;
    repeat (4) @(negedge clk);
    rx_level = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 flag not early", frame_err, 1'b0);
    @(negedge clk);
    check("R7 flag on runt", frame_err, 1'b1);
    @(negedge clk);
    check("R7 flag lasts one tick", frame_err, 1'b0);
    repeat (20) @(negedge clk);
    check("R7 runt not on output", seen_low, 1'b0);

    // R7 boundary: mid+1 ticks is kept and not flagged
    seen_err = 1'b0;
    rx_level = 1'b0;
    repeat (5) @(negedge clk);
    rx_level = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 pulse of mid+1 kept", bit_out, 1'b0);
    repeat (20) @(negedge clk);
    check("R7 no flag for mid+1", seen_err, 1'b0);
    check("R5 back to high level", bit_out, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule